// File: doc/BRIEF.md
# Event Timestamp Capture Queue

The block records the moment that protocol event messages cross the media interface. An upstream parser presents a one-cycle strobe with fields it has already extracted: a 4-bit message type, a 12-bit checksum and a 16-bit sequence number. On that same cycle the block samples the running time of day, which arrives as 48 bits of seconds and 32 bits of nanoseconds. If software has enabled that message type, the block packs the time and the message identity into one 128-bit record and places it in a 16-entry FIFO.

Software drains the FIFO with a request and acknowledge handshake. It can also read the fill level, flush the queue and clear a sticky overflow flag. The transmit path and the receive path each use their own instance, and each instance sits in its own register window.

Top module: `stamp_capture_queue`

## Requirements
- R1: Each record has this layout. Bits [127:112] are zero. Bits [111:64] hold the seconds. Bits [63:32] hold the nanoseconds. Bits [31:28] hold the message type, bits [27:16] the checksum and bits [15:0] the sequence number.
- R2: The time written into a record is the value on `tod_sec`/`tod_ns` in the cycle that `evt_stb` is high. Later changes to the time inputs do not alter the record.
- R3: Bit n of the type mask enables message type n. The mask resets to all ones. A strobe whose type bit is clear adds nothing to the queue. A mask write takes effect from the next cycle, so a strobe in the same cycle as the write uses the old mask.
- R4: An accepted strobe raises `fill_level` by one on the following cycle.
- R5: `fill_level` never exceeds 16. An enabled strobe that arrives while the queue holds 16 entries is dropped, even if a pop happens in the same cycle.
- R6: A dropped enabled strobe sets `ovf_flag`, and the flag stays set until `ovf_clear`. If a drop and a clear fall in the same cycle, the flag stays set.
- R7: A request made while `rd_valid` is low and the queue is not empty removes the oldest record. In the next cycle `rd_valid` is high and `rd_data` carries that record. Records come out in arrival order.
- R8: `rd_valid` and `rd_data` hold steady until `rd_ack`, and `rd_valid` goes low in the cycle after the acknowledge. A request made while `rd_valid` is high is ignored.
- R9: A request made while the queue is empty leaves `rd_valid` low and `fill_level` at zero.
- R10: `q_clear` sets `fill_level` to zero on the next cycle. It discards any push or pop in the same cycle and does not affect a record already on `rd_data`.
- R11: A push and a pop in the same cycle, with the queue not full, leave `fill_level` unchanged and both take effect.
- R12: After reset, `fill_level` is 0, `rd_valid` and `ovf_flag` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_stb | input | 1 | One-cycle capture strobe from the parser |
| evt_msg_id | input | 4 | Message type |
| evt_cksum | input | 12 | Message checksum |
| evt_seq | input | 16 | Message sequence number |
| tod_sec | input | 48 | Current time, seconds |
| tod_ns | input | 32 | Current time, nanoseconds |
| mask_wr | input | 1 | Write strobe for the type mask |
| mask_wdata | input | 16 | New type mask value |
| mask_q | output | 16 | Current type mask |
| q_clear | input | 1 | Flush the queue |
| ovf_clear | input | 1 | Clear the overflow flag |
| rd_req | input | 1 | Read request |
| rd_ack | input | 1 | Acknowledge for the presented record |
| rd_valid | output | 1 | `rd_data` holds a record |
| rd_data | output | 128 | Presented record |
| fill_level | output | 5 | Number of queued records |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Four pairs of functions can fall in the same cycle: a capture and a pop, a capture and a flush, a drop and an overflow clear, and a mask write and a strobe. The bench drives each pair on one clock edge. With a partly filled queue, the capture plus pop must leave the fill level unchanged, and both records must later come out intact and in order. With a full queue, the same pair must drop the capture, lower the level to 15 and set the overflow flag. The flush must win over the capture, and the mask write must leave the same-cycle strobe to be judged by the old mask. In every case the bench compares the result against its own queue model.

// File: rtl/scq_pkg.sv
package scq_pkg;
  localparam int ID_W   = 4;
  localparam int CK_W   = 12;
  localparam int SEQ_W  = 16;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int PAD_W  = 16;
  localparam int MASK_W = 1 << ID_W;

  typedef struct packed {
    logic [PAD_W-1:0] pad;
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [ID_W-1:0]  msg_id;
    logic [CK_W-1:0]  cksum;
    logic [SEQ_W-1:0] seq;
  } scq_rec_t;

  localparam int REC_W = $bits(scq_rec_t);

  // Build one queue record from the sampled time and message fields.
  function automatic scq_rec_t scq_pack(
    input logic [SEC_W-1:0] sec,
    input logic [NS_W-1:0]  ns,
    input logic [ID_W-1:0]  msg_id,
    input logic [CK_W-1:0]  cksum,
    input logic [SEQ_W-1:0] seq
  );
    scq_rec_t r;
    r.pad    = '0;
    r.sec    = sec;
    r.ns     = ns;
    r.msg_id = msg_id;
    r.cksum  = cksum;
    r.seq    = seq;
    return r;
  endfunction

  // Advance a ring pointer, wrapping at the depth.
  function automatic int unsigned scq_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/scq_mask_gate.sv
module scq_mask_gate
  import scq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              stb,
  input  logic [ID_W-1:0]   msg_id,
  output logic [MASK_W-1:0] mask_q,
  output logic              accept
);
  logic [MASK_W-1:0] id_dec;

  always_comb begin
    id_dec = '0;
    id_dec[msg_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  // The mask that is already registered is used, so a write in the same cycle does not apply yet.
  assign accept = stb & |(id_dec & mask_q);
endmodule

// File: rtl/scq_fifo.sv
module scq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  import scq_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(scq_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(scq_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/scq_read_port.sv
module scq_read_port #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             rd_ack,
  input  logic             q_empty,
  input  logic             take,
  input  logic [WIDTH-1:0] head,
  output logic             want_pop,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  // A request is honoured only while nothing is on offer and a record is waiting.
  assign want_pop = rd_req & ~rd_valid & ~q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (take) begin
      rd_valid <= 1'b1;
      rd_data  <= head;
    end else if (rd_valid && rd_ack) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stamp_capture_queue.sv
module stamp_capture_queue
  import scq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_stb,
  input  logic [3:0]        evt_msg_id,
  input  logic [11:0]       evt_cksum,
  input  logic [15:0]       evt_seq,
  input  logic [47:0]       tod_sec,
  input  logic [31:0]       tod_ns,
  input  logic              mask_wr,
  input  logic [15:0]       mask_wdata,
  output logic [15:0]       mask_q,
  input  logic              q_clear,
  input  logic              ovf_clear,
  input  logic              rd_req,
  input  logic              rd_ack,
  output logic              rd_valid,
  output logic [127:0]      rd_data,
  output logic [CNT_W-1:0]  fill_level,
  output logic              ovf_flag
);
  // Named internal events, also seen by the checker.
  logic     type_hit;
  logic     push_en;
  logic     pop_en;
  logic     drop_evt;
  logic     want_pop;
  logic     q_full;
  logic     q_empty;
  scq_rec_t cap_rec;
  logic [REC_W-1:0] head;

  assign cap_rec = scq_pack(tod_sec, tod_ns, evt_msg_id, evt_cksum, evt_seq);

  scq_mask_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .mask_wdata(mask_wdata),
    .stb       (evt_stb),
    .msg_id    (evt_msg_id),
    .mask_q    (mask_q),
    .accept    (type_hit)
  );

  // Fullness is judged before any same-cycle pop, and a flush overrides both push and pop.
  assign push_en  = type_hit & ~q_full & ~q_clear;
  assign drop_evt = type_hit &  q_full & ~q_clear;
  assign pop_en   = want_pop & ~q_clear;

  scq_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (q_clear),
    .push     (push_en),
    .push_data(cap_rec),
    .pop      (pop_en),
    .head     (head),
    .count    (fill_level),
    .full     (q_full),
    .empty    (q_empty)
  );

  scq_read_port #(.WIDTH(REC_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .q_empty (q_empty),
    .take    (pop_en),
    .head    (head),
    .want_pop(want_pop),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // Sticky overflow; a new drop outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_flag <= 1'b0;
    else if (drop_evt)  ovf_flag <= 1'b1;
    else if (ovf_clear) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/scq_checker.sv
module scq_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_stb,
  input logic [3:0]       evt_msg_id,
  input logic [15:0]      mask_q,
  input logic             q_clear,
  input logic             ovf_clear,
  input logic             rd_ack,
  input logic             rd_valid,
  input logic [127:0]     rd_data,
  input logic [CNT_W-1:0] fill_level,
  input logic             ovf_flag,
  input logic             push_en,
  input logic             pop_en,
  input logic             drop_evt
);
  assert_masked_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb && !mask_q[evt_msg_id]) |-> !push_en);

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |=> (fill_level == $past(fill_level) + 1'b1));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data)));

  assert_ack_drops_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ack) |=> !rd_valid);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> (fill_level == '0));

  assert_pushpop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |=> $stable(fill_level));
endmodule

bind stamp_capture_queue scq_checker #(.DEPTH(DEPTH)) u_scq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_stb   (evt_stb),
  .evt_msg_id(evt_msg_id),
  .mask_q    (mask_q),
  .q_clear   (q_clear),
  .ovf_clear (ovf_clear),
  .rd_ack    (rd_ack),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .fill_level(fill_level),
  .ovf_flag  (ovf_flag),
  .push_en   (push_en),
  .pop_en    (pop_en),
  .drop_evt  (drop_evt)
);

// File: tb/stamp_capture_queue_bench.sv
module stamp_capture_queue_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_stb = 0;
  logic [3:0]   evt_msg_id = 0;
  logic [11:0]  evt_cksum = 0;
  logic [15:0]  evt_seq = 0;
  logic [47:0]  tod_sec = 0;
  logic [31:0]  tod_ns = 0;
  logic         mask_wr = 0;
  logic [15:0]  mask_wdata = 0;
  logic [15:0]  mask_q;
  logic         q_clear = 0, ovf_clear = 0, rd_req = 0, rd_ack = 0;
  logic         rd_valid;
  logic [127:0] rd_data;
  logic [4:0]   fill_level;
  logic         ovf_flag;

  int n_chk = 0, n_bad = 0;
  logic [127:0] mq[$];
  logic [15:0]  m_mask = 16'hFFFF;
  logic         m_ovf = 0;

  always #10 clk = ~clk;

  stamp_capture_queue u_stamp_capture_queue (.*);

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic logic [127:0] exp_rec(input logic [47:0] s, input logic [31:0] n,
                                           input logic [3:0] id, input logic [11:0] c, input logic [15:0] q);
    return ({80'd0, s} << 64) | ({96'd0, n} << 32) | (128'(id) << 28) | (128'(c) << 16) | 128'(q);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Present one capture; the model applies the mask held before this cycle.
  task automatic strobe(input logic [3:0] id, input int k, input bit with_pop);
    logic [47:0] s;
    logic [31:0] n;
    bit pushed;
    s = 48'h0A00_0000_0000 + 48'(k * 7919);
    n = 32'd999_000_000 - 32'(k * 131);
    evt_stb = 1; evt_msg_id = id; evt_cksum = 12'(k * 37 + 5); evt_seq = 16'(k * 257 + 3);
    tod_sec = s; tod_ns = n;
    rd_req = with_pop;
    pushed = 0;
    if (m_mask[id]) begin
      if (mq.size() < 16) pushed = 1;
      else m_ovf = 1;
    end
    tick();
    evt_stb = 0; rd_req = 0;
    tod_sec = ~s; tod_ns = ~n;
    if (with_pop) void'(mq.pop_front());
    if (pushed) mq.push_back(exp_rec(s, n, id, evt_cksum, evt_seq));
  endtask

  task automatic set_mask(input logic [15:0] m);
    mask_wr = 1; mask_wdata = m; tick(); mask_wr = 0; m_mask = m;
  endtask

  task automatic read_one(input string tag);
    logic [127:0] e;
    logic [4:0] lvl;
    e = mq.pop_front();
    rd_req = 1; tick(); rd_req = 0;
    chk(rd_valid === 1'b1, {tag, " valid"}, 128'(rd_valid), 1);
    chk(rd_data === e, tag, rd_data, e);
    chk(rd_data[127:112] === 16'h0, "R1 pad", rd_data, e);
    lvl = fill_level;
    rd_req = 1; tick(); rd_req = 0;
    chk(rd_valid === 1'b1 && rd_data === e, "R8 hold", rd_data, e);
    chk(fill_level === lvl, "R8 ignored req", 128'(fill_level), 128'(lvl));
    rd_ack = 1; tick(); rd_ack = 0;
    chk(rd_valid === 1'b0, "R8 ack", 128'(rd_valid), 0);
  endtask

  initial begin
    repeat (3) tick();
    chk(fill_level === 0 && rd_valid === 0 && ovf_flag === 0 && rd_data === 0, "R12 reset",
        {rd_data[122:0], fill_level}, 0);
    rst_n = 1; tick();
    chk(mask_q === 16'hFFFF, "R3 reset mask", 128'(mask_q), 128'hFFFF);

    // Sweep all types under several masks.
    foreach (m_list[mi]) begin
      set_mask(m_list[mi]);
      chk(mask_q === m_list[mi], "R3 mask readback", 128'(mask_q), 128'(m_list[mi]));
      for (int t = 0; t < 16; t++) begin
        strobe(4'(t), mi * 16 + t, 0);
        chk(fill_level === 5'(mq.size()), "R4 level per strobe", 128'(fill_level), 128'(mq.size()));
      end
      while (mq.size() > 0) read_one("R7 order/R1/R2 record");
      rd_req = 1; tick(); rd_req = 0;
      chk(rd_valid === 0 && fill_level === 0, "R9 empty read", 128'(rd_valid), 0);
    end

    // Fill completely, then overflow.
    set_mask(16'hFFFF);
    for (int t = 0; t < 16; t++) strobe(4'(t), 100 + t, 0);
    chk(fill_level === 16, "R5 full", 128'(fill_level), 16);
    strobe(4'd2, 200, 0);
    chk(fill_level === 16, "R5 drop at full", 128'(fill_level), 16);
    chk(ovf_flag === 1, "R6 overflow set", 128'(ovf_flag), 1);
    ovf_clear = 1; strobe(4'd4, 201, 0); ovf_clear = 0;
    chk(ovf_flag === 1, "R6 drop beats clear", 128'(ovf_flag), 1);
    ovf_clear = 1; tick(); ovf_clear = 0; m_ovf = 0;
    chk(ovf_flag === 0, "R6 clear", 128'(ovf_flag), 0);

    // Full queue: capture and pop in the same cycle; the capture is dropped.
    strobe(4'd6, 202, 1);
    chk(fill_level === 15, "R5 full with pop", 128'(fill_level), 15);
    chk(ovf_flag === 1, "R6 drop with pop", 128'(ovf_flag), 1);
    rd_ack = 1; tick(); rd_ack = 0;
    ovf_clear = 1; tick(); ovf_clear = 0;

    // Not full: push and pop together keep the level.
    strobe(4'd7, 203, 1);
    chk(fill_level === 15, "R11 push+pop", 128'(fill_level), 15);
    rd_ack = 1; tick(); rd_ack = 0;
    while (mq.size() > 0) read_one("R11 order after push+pop");

    // Mask write and strobe in the same cycle use the old mask.
    mask_wr = 1; mask_wdata = 16'h0000;
    strobe(4'd3, 300, 0);
    mask_wr = 0; m_mask = 16'h0000;
    chk(fill_level === 1, "R3 old mask same cycle", 128'(fill_level), 1);
    strobe(4'd3, 301, 0);
    chk(fill_level === 1, "R3 new mask blocks", 128'(fill_level), 1);
    set_mask(16'hFFFF);

    // Flush while a record is on offer and a capture arrives.
    strobe(4'd1, 302, 0);
    rd_req = 1; tick(); rd_req = 0;
    begin
      logic [127:0] held;
      held = mq.pop_front();
      q_clear = 1; evt_stb = 1; evt_msg_id = 4'd9; tick(); q_clear = 0; evt_stb = 0;
      mq.delete();
      chk(fill_level === 0, "R10 clear level", 128'(fill_level), 0);
      chk(rd_valid === 1 && rd_data === held, "R10 output kept", rd_data, held);
      rd_ack = 1; tick(); rd_ack = 0;
      tick();
      chk(fill_level === 0, "R10 same-cycle push discarded", 128'(fill_level), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  logic [15:0] m_list [4] = '{16'hFFFF, 16'hA5A5, 16'h0001, 16'h0000};
endmodule